// File: doc/BRIEF.md
# Single-Clock FIFO with Replay from Location Zero

This block is a first-in first-out buffer whose write and read sides share one clock. Besides normal streaming, it can replay: on request, the read side rewinds to the first storage location. Everything written since reset can then be read out again without the writer having to send it twice. A replay is set up only when the read side and the write side are both idle in that cycle. It is only legal while every word written since reset is still held in memory, which means the write pointer has never wrapped.

Two timing variants are selected at elaboration. In the registered-read variant, each word leaves the buffer only on a cycle with read enable, and a "no data" flag shows that nothing can be read. In the look-ahead variant, the head word is loaded into the output register on its own and "no data" drops when that word is present. Read enable then discards the shown word. Both variants provide half-full, almost-empty and almost-full indications. The thresholds are fixed parameters.

Top module: `syncfifo_replay`

## Requirements
- R1: A write with `wr_en` high stores `din` unless the memory already holds DEPTH words, in which case that write is dropped and does not change the data read out later. Data leaves in write order.
- R2: Registered-read variant (`FWFT`=0): a cycle with `rd_en` high while a word is stored and no replay setup is running puts that word on `dout` after the clock edge. `nodata` is 1 when the memory is empty or a replay setup is running.
- R3: Look-ahead variant (`FWFT`=1): the head word is moved to `dout` without `rd_en` on the first edge when the output register is empty and a word is stored. `nodata` is 0 exactly while `dout` holds a valid word. `rd_en` discards that word. The capacity is DEPTH+1.
- R4: A replay request (`rewind`=1 on an edge) is accepted only when `wr_en`=0, `rd_en`=0, no setup is running, and the number of words written since reset N satisfies 1 ≤ N ≤ DEPTH+FWFT−2. When it is accepted, reading restarts from the first word written after reset, and the occupancy becomes N.
- R5: Replay setup covers the two clock edges that follow the accepting edge. During setup `nodata` is 1 and read enable is ignored. Writes during setup are still taken. In the look-ahead variant, the first word appears one edge after setup ends.
- R6: A replay request that is not accepted changes nothing except that `rewind_err` is 1 for the single cycle after that edge. A write or read in the same cycle proceeds normally.
- R7: `half_full` is 1 when the occupancy exceeds DEPTH/2. It follows the new occupancy immediately after a replay is accepted.
- R8: `almost_empty` is 1 when the occupancy is at most AE_LVL. After an accepted replay, it keeps its prior value until the second edge after the accepting edge.
- R9: `almost_full` is 1 when the occupancy is at least DEPTH+FWFT−AF_LVL.
- R10: After a synchronous reset (`rst_n`=0 on an edge): `nodata`=1, `half_full`=0, `almost_empty`=1, `almost_full`=0, `rewind_err`=0, `dout`=0, and the written-word count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request (pop in look-ahead variant) |
| rewind | input | 1 | Replay request |
| din | input | DW | Write data |
| dout | output | DW | Read data register |
| nodata | output | 1 | No word available to read |
| half_full | output | 1 | Occupancy above DEPTH/2 |
| almost_empty | output | 1 | Occupancy at or below AE_LVL |
| almost_full | output | 1 | Occupancy at or above capacity minus AF_LVL |
| rewind_err | output | 1 | One-cycle pulse for a rejected replay request |

## Verification
Two events can collide: a replay request can land in the same cycle as a write or a read, and a write can arrive while a replay setup is running. The bench provokes the first collision directly, and it also gets it through random traffic in which replay requests are mixed with reads and writes at random. The colliding request must be rejected with an error pulse while the write or read still takes effect. A write that lands inside the setup window must be counted into the replayed occupancy. Both variants run on identical stimulus, and a queue-based model judges them every cycle.

// File: rtl/replay_pkg.sv
package replay_pkg;

  // Words the buffer can hold: the look-ahead variant adds its output register.
  function automatic int cap_of(input int depth, input bit fwft);
    return depth + (fwft ? 1 : 0);
  endfunction

  // Largest written-word count at which a replay is still legal.
  function automatic int limit_of(input int depth, input bit fwft);
    return cap_of(depth, fwft) - 2;
  endfunction

  // Counter width able to hold counts up to depth+1.
  function automatic int cnt_width(input int depth);
    return $clog2(depth + 2);
  endfunction

  function automatic bit is_half(input int occ, input int depth);
    return occ > (depth / 2);
  endfunction

  function automatic bit is_low(input int occ, input int lvl);
    return occ <= lvl;
  endfunction

  function automatic bit is_high(input int occ, input int cap, input int lvl);
    return occ >= (cap - lvl);
  endfunction

endpackage

// File: rtl/replay_store.sv
module replay_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/replay_ctrl.sv
module replay_ctrl
  import replay_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter bit FWFT  = 1'b0,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = cnt_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          rew_req,
  input  logic [DW-1:0] rdata,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] occ,
  output logic          nodata,
  output logic          busy,
  output logic          rew_go,
  output logic          rew_err
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] LIM_C  = CW'(limit_of(DEPTH, FWFT));

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] mem_cnt;
  logic [CW-1:0] wr_total;   // writes since reset, saturating at LIM_C+1
  logic [1:0]    bcnt;       // remaining setup edges
  logic          ovalid;     // look-ahead output register holds a word
  logic          full, have_word, wr_fire, pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign busy      = (bcnt != 2'd0);
  assign full      = (mem_cnt == FULL_C);
  assign have_word = (mem_cnt != '0);
  assign rew_go    = rew_req & ~wr_en & ~rd_en & ~busy &
                     (wr_total != '0) & (wr_total <= LIM_C);
  assign wr_fire   = wr_en & ~full & ~rew_go;

  generate
    if (FWFT) begin : g_pop_ahead
      assign pop = ~busy & ~rew_go & have_word & (~ovalid | rd_en);
    end else begin : g_pop_reg
      assign pop = rd_en & ~busy & ~rew_go & have_word;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      mem_cnt  <= '0;
      wr_total <= '0;
      bcnt     <= 2'd0;
      ovalid   <= 1'b0;
      dout     <= '0;
      rew_err  <= 1'b0;
    end else begin
      rew_err <= rew_req & ~rew_go;
      if (wr_fire) wptr <= ptr_inc(wptr);
      if (wr_fire && (wr_total <= LIM_C)) wr_total <= wr_total + 1'b1;
      if (rew_go) begin
        rptr    <= '0;
        mem_cnt <= wr_total;       // write pointer minus location zero
        bcnt    <= 2'd2;
        ovalid  <= 1'b0;
      end else begin
        if (pop) begin
          rptr <= ptr_inc(rptr);
          dout <= rdata;
        end
        mem_cnt <= mem_cnt + CW'(wr_fire) - CW'(pop);
        if (busy) bcnt <= bcnt - 2'd1;
        if (FWFT) begin
          if (pop)        ovalid <= 1'b1;
          else if (rd_en) ovalid <= 1'b0;
        end
      end
    end
  end

  assign we     = wr_fire;
  assign waddr  = wptr;
  assign raddr  = rptr;
  assign occ    = mem_cnt + CW'(ovalid);
  assign nodata = FWFT ? ~ovalid : (~have_word | busy);

  // R1: stored words never exceed the memory size
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cnt <= FULL_C);

  // R4: an accepted replay restarts at location zero with occupancy N
  p_rewind_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rew_go |=> (rptr == '0) && (mem_cnt == $past(wr_total)));

  // R5: setup spans exactly two edges after acceptance
  p_setup_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rew_go |=> busy ##1 busy ##1 !busy);

  // R5: nothing can be read while setup runs
  p_setup_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> nodata && !pop);

  // R6: every rejected request yields an error pulse, and only those do
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rew_req && !rew_go) |=> rew_err);
  p_err_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rew_err |-> $past(rew_req));

endmodule

// File: rtl/replay_flags.sv
module replay_flags
  import replay_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter bit FWFT   = 1'b0,
  parameter int AE_LVL = 2,
  parameter int AF_LVL = 2,
  localparam int CW    = cnt_width(DEPTH),
  localparam int CAP   = cap_of(DEPTH, FWFT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] occ,
  input  logic          busy,
  input  logic          rew_go,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);

  logic ae_hold;

  always_ff @(posedge clk) begin
    if (!rst_n)      ae_hold <= 1'b1;
    else if (rew_go) ae_hold <= almost_empty;
  end

  assign half_full    = is_half(int'(occ), DEPTH);
  assign almost_full  = is_high(int'(occ), CAP, AF_LVL);
  assign almost_empty = busy ? ae_hold : is_low(int'(occ), AE_LVL);

  // R8: almost-empty is frozen over the setup window
  p_ae_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(almost_empty));

endmodule

// File: rtl/syncfifo_replay.sv
module syncfifo_replay
  import replay_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter bit FWFT   = 1'b0,
  parameter int AE_LVL = 2,
  parameter int AF_LVL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          rewind,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          nodata,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full,
  output logic          rewind_err
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = cnt_width(DEPTH);

  logic          we, busy, rew_go;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] rdata;
  logic [CW-1:0] occ;

  replay_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (din),
    .raddr (raddr),
    .rdata (rdata)
  );

  replay_ctrl #(.DW(DW), .DEPTH(DEPTH), .FWFT(FWFT)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rew_req (rewind),
    .rdata   (rdata),
    .we      (we),
    .waddr   (waddr),
    .raddr   (raddr),
    .dout    (dout),
    .occ     (occ),
    .nodata  (nodata),
    .busy    (busy),
    .rew_go  (rew_go),
    .rew_err (rewind_err)
  );

  replay_flags #(.DEPTH(DEPTH), .FWFT(FWFT), .AE_LVL(AE_LVL), .AF_LVL(AF_LVL)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .occ          (occ),
    .busy         (busy),
    .rew_go       (rew_go),
    .half_full    (half_full),
    .almost_empty (almost_empty),
    .almost_full  (almost_full)
  );

  // R10: reset leaves the buffer with nothing to read
  p_reset_state_r10: assert property (@(posedge clk)
    !rst_n |=> nodata && !half_full && almost_empty && !rewind_err);

endmodule

// File: tb/test_syncfifo_replay.sv
`timescale 1ns/1ps

module replay_model #(
  parameter int    DW    = 8,
  parameter int    DEPTH = 8,
  parameter bit    FWFT  = 1'b0,
  parameter int    AE    = 2,
  parameter int    AF    = 2,
  parameter string TAG   = "reg"
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr,
  input logic          rd,
  input logic          rew,
  input logic [DW-1:0] din,
  input logic [DW-1:0] q,
  input logic          nd,
  input logic          hf,
  input logic          ae,
  input logic          af,
  input logic          err
);
  localparam int CAP = DEPTH + (FWFT ? 1 : 0);
  localparam int LIM = CAP - 2;

  logic [DW-1:0] store [int];
  int wi, ri, bcnt, occ, mc;
  bit ov, aeh, merr, seen, acc, bsy, e_nd, e_ae;
  logic [DW-1:0] dq;
  int checks = 0;
  int bad = 0;

  function automatic bit ae_now();
    return (bcnt > 0) ? aeh : ((wi - ri + int'(ov)) <= AE);
  endfunction

  always @(posedge clk) begin
    seen = 1'b1;
    if (!rst_n) begin
      store.delete();
      wi = 0; ri = 0; bcnt = 0; ov = 0; dq = '0; merr = 0; aeh = 1;
    end else begin
      mc  = wi - ri;
      bsy = (bcnt > 0);
      acc = rew && !wr && !rd && !bsy && wi >= 1 && wi <= LIM;
      merr = rew && !acc;
      if (acc) begin
        aeh = ae_now(); ri = 0; bcnt = 2; ov = 0;
      end else begin
        if (!FWFT) begin
          if (rd && !bsy && mc > 0) begin dq = store[ri]; ri++; end
        end else begin
          if (!bsy && (!ov || rd) && mc > 0) begin dq = store[ri]; ri++; ov = 1; end
          else if (rd) ov = 0;
        end
        if (wr && mc < DEPTH) begin store[wi] = din; wi++; end
        if (bcnt > 0) bcnt--;
      end
    end
  end

  task automatic cmp(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", TAG, req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (seen) begin
      occ  = wi - ri + int'(ov);
      e_nd = FWFT ? !ov : ((wi == ri) || (bcnt > 0));
      e_ae = (bcnt > 0) ? aeh : (occ <= AE);
      cmp("R1/R2/R3/R4 dout", int'(q), int'(dq));
      cmp("R2/R3/R5 nodata", int'(nd), int'(e_nd));
      cmp("R7 half_full", int'(hf), int'(occ > DEPTH / 2));
      cmp("R8 almost_empty", int'(ae), int'(e_ae));
      cmp("R9 almost_full", int'(af), int'(occ >= CAP - AF));
      cmp("R6 rewind_err", int'(err), int'(merr));
    end
  end
endmodule

module test_syncfifo_replay;
  localparam int DW = 8, DEPTH = 8, AE = 2, AF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0, rew = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] q_s, q_f;
  logic nd_s, hf_s, ae_s, af_s, er_s;
  logic nd_f, hf_f, ae_f, af_f, er_f;
  int checks = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  syncfifo_replay #(.DW(DW), .DEPTH(DEPTH), .FWFT(1'b0), .AE_LVL(AE), .AF_LVL(AF)) i_syncfifo_replay (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .rd_en(rd), .rewind(rew), .din(din),
    .dout(q_s), .nodata(nd_s), .half_full(hf_s), .almost_empty(ae_s),
    .almost_full(af_s), .rewind_err(er_s));

  syncfifo_replay #(.DW(DW), .DEPTH(DEPTH), .FWFT(1'b1), .AE_LVL(AE), .AF_LVL(AF)) i_syncfifo_replay_ft (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .rd_en(rd), .rewind(rew), .din(din),
    .dout(q_f), .nodata(nd_f), .half_full(hf_f), .almost_empty(ae_f),
    .almost_full(af_f), .rewind_err(er_f));

  replay_model #(.DW(DW), .DEPTH(DEPTH), .FWFT(1'b0), .AE(AE), .AF(AF), .TAG("reg")) m_reg (
    .clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .rew(rew), .din(din),
    .q(q_s), .nd(nd_s), .hf(hf_s), .ae(ae_s), .af(af_s), .err(er_s));

  replay_model #(.DW(DW), .DEPTH(DEPTH), .FWFT(1'b1), .AE(AE), .AF(AF), .TAG("ahead")) m_ahead (
    .clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .rew(rew), .din(din),
    .q(q_f), .nd(nd_f), .hf(hf_f), .ae(ae_f), .af(af_f), .err(er_f));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d",
               checks + m_reg.checks + m_ahead.checks, bad + m_reg.bad + m_ahead.bad);
      $finish;
    end
  endtask

  // drive one cycle of stimulus; returns at the following falling edge
  task automatic step(input logic w, input logic r, input logic rw, input logic [DW-1:0] d);
    wr = w; rd = r; rew = rw; din = d;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    // R10: reset values
    chk("R10 nodata reg", int'(nd_s), 1);
    chk("R10 nodata ahead", int'(nd_f), 1);
    chk("R10 half_full", int'(hf_s | hf_f), 0);
    chk("R10 almost_empty", int'(ae_s & ae_f), 1);
    chk("R10 almost_full", int'(af_s | af_f), 0);
    chk("R10 rewind_err", int'(er_s | er_f), 0);
    chk("R10 dout", int'(q_s), 0);
    rst_n = 1'b1;

    // R6: replay with nothing written is refused
    step(0, 0, 1, 0);
    chk("R6 err on empty replay reg", int'(er_s), 1);
    chk("R6 err on empty replay ahead", int'(er_f), 1);
    step(0, 0, 0, 0);
    chk("R6 err is one cycle", int'(er_s | er_f), 0);

    // R1/R2/R3: five words, three read
    for (int i = 0; i < 5; i++) step(1, 0, 0, DW'(8'h10 + i));
    step(0, 0, 0, 0);
    chk("R3 head word shown without read", int'(q_f), 8'h10);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
    chk("R2 third word read", int'(q_s), 8'h12);

    // R6: replay colliding with a read is refused, read still happens
    step(0, 1, 1, 0);
    chk("R6 collide err", int'(er_s), 1);
    chk("R6 collide read proceeds", int'(q_s), 8'h13);

    // R4/R5: clean replay
    step(0, 0, 1, 0);
    chk("R5 setup nodata reg", int'(nd_s), 1);
    chk("R5 setup nodata ahead", int'(nd_f), 1);
    chk("R7 half_full after replay", int'(hf_s), 1);
    step(0, 1, 0, 0);
    chk("R5 read ignored in setup", int'(q_s), 8'h13);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R3/R4 first word reappears", int'(q_f), 8'h10);
    chk("R3 ready after setup", int'(nd_f), 0);
    step(0, 1, 0, 0);
    chk("R4 replay starts at word zero", int'(q_s), 8'h10);
    for (int i = 0; i < 6; i++) step(0, 1, 0, 0);

    // R1/R9: overflow then drain
    do_reset();
    for (int i = 0; i < DEPTH + 3; i++) step(1, 0, 0, DW'(8'h40 + i));
    chk("R9 almost_full reg", int'(af_s), 1);
    chk("R9 almost_full ahead", int'(af_f), 1);
    chk("R7 half_full when full", int'(hf_s), 1);
    // R6: too many words written for a replay
    step(0, 0, 1, 0);
    chk("R6 over-limit err", int'(er_s & er_f), 1);
    for (int i = 0; i < DEPTH + 3; i++) step(0, 1, 0, 0);
    chk("R1 last kept word reg", int'(q_s), 8'h40 + DEPTH - 1);
    chk("R1 last kept word ahead", int'(q_f), 8'h40 + DEPTH);

    // mixed traffic with replays and writes in setup windows
    for (int blk = 0; blk < 12; blk++) begin
      do_reset();
      for (int i = 0; i < 250; i++)
        step(($urandom % 100) < 50, ($urandom % 100) < 35,
             ($urandom % 100) < 6, DW'($urandom));
    end
    step(0, 0, 0, 0);
    finish_run();
  end
endmodule